// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block carries stereo samples between a 24-bit parallel sample bus and a three-wire serial audio link made of a bit clock, a word select and a data line. Transmit words are serialized onto the data output, and serial input data is assembled into words and delivered per channel with a one-cycle strobe. Three framings are available, and the right-justified framing takes one of four word lengths.

Every half frame is 32 bit clocks long, so a stereo frame is 64 bit clocks. The port runs entirely in the system clock domain. As clock master, it derives the bit clock from the system clock with a programmable divider and produces word select itself. As clock slave, it synchronizes an external bit clock and word select and follows their edges. In both modes the data output changes on the falling bit-clock edge and the data input is sampled on the rising edge.

Top module: `aud_serial_port`

## Requirements
- R1: While reset is asserted and right after it is released in slave mode, sdOut, sckOut, wsOut, txTake, rxLeftValid and rxRightValid are all 0.
- R2: With cfgFormat = 0 (I2S), word select low marks the left channel. The 24-bit word's MSB is sent one bit clock after the word-select edge, MSB first, and every other slot of the half frame carries 0.
- R3: With cfgFormat = 1 (or 3), the framing is left-justified with word select high for the left channel. The MSB is sent in the first bit clock after the word-select edge, and the 8 trailing slots carry 0.
- R4: With cfgFormat = 2, the framing is right-justified with word select high for the left channel. The top W bits of the sample are sent so that the LSB falls in slot 31, the last slot before the next word-select edge, and the leading slots carry 0. W is 16, 18, 20 or 24 for cfgWidth 0, 1, 2 or 3.
- R5: A received word is captured from the same slots its framing uses for transmit. It is delivered left-aligned on the 24-bit bus, with the bits below its length set to 0.
- R6: Each completed half frame produces exactly one single-cycle pulse: rxLeftValid for the left channel or rxRightValid for the right. Both are never high together, and the word is valid on rxLeft or rxRight while the pulse is high.
- R7: In master mode, sckOut has a period of 2*(cfgDiv+1) system clocks. wsOut holds each level for 32 bit clocks and changes only together with a falling sckOut edge.
- R8: In slave mode the port times everything from sckIn and wsIn, with 32 bit clocks per channel, and holds sckOut and wsOut at 0.
- R9: At the start of each left half frame, both txLeft and txRight are latched and txTake pulses for one cycle. Changing txLeft or txRight later in that frame does not alter what the frame sends.
- R10: No receive strobe is produced until the first word-select transition has been seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgMaster | input | 1 | 1: port drives bit clock and word select; 0: follows external ones |
| cfgFormat | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| cfgWidth | input | 2 | Right-justified length: 0=16, 1=18, 2=20, 3=24 bits |
| cfgDiv | input | DIV_W | Master bit-clock half period minus one, in system clocks |
| sckIn | input | 1 | External bit clock (slave) |
| wsIn | input | 1 | External word select (slave) |
| sdIn | input | 1 | Serial data in |
| sckOut | output | 1 | Generated bit clock (master) |
| wsOut | output | 1 | Generated word select (master) |
| sdOut | output | 1 | Serial data out |
| txLeft | input | 24 | Left sample to send |
| txRight | input | 24 | Right sample to send |
| txTake | output | 1 | Pulse: both transmit samples latched |
| rxLeft | output | 24 | Last received left word |
| rxRight | output | 24 | Last received right word |
| rxLeftValid | output | 1 | Pulse: rxLeft updated |
| rxRightValid | output | 1 | Pulse: rxRight updated |

## Verification
The bench builds the port with its default 8-bit divider width. In slave mode it drives an external bit clock of 16 system clocks, which leaves room for the two-stage synchronizer and edge detector inside each bit half period. This setup reaches all three framings and all four right-justified lengths, and the bench decodes the data line independently of the port. In master mode it runs the divider at settings 3 and 1 with the data line looped back, which checks the generated period, the word-select length and the receive path against the port's own clocking.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;

  localparam int SAMPLE_W   = 24;
  localparam int HALF_SLOTS = 32;
  localparam int SLOT_W     = $clog2(HALF_SLOTS);

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_MSBJ = 2'd1,
    FMT_LSBJ = 2'd2,
    FMT_ALT  = 2'd3
  } fmt_e;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic              rise;       // bit clock rising edge seen this cycle
    logic              fall;       // bit clock falling edge seen this cycle
    logic [SLOT_W-1:0] slot;       // slot the edge belongs to
    logic              chanRight;  // slot is in the right half frame
    logic              aligned;    // a word-select transition has been seen
    logic              loadTx;     // left half frame begins now
  } apStrobe_t;

  function automatic int unsigned wordBits(input logic [1:0] fmt, input logic [1:0] wcode);
    if (fmt != FMT_LSBJ) return SAMPLE_W;
    case (wcode)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int unsigned firstSlot(input logic [1:0] fmt, input logic [1:0] wcode);
    if (fmt == FMT_I2S)  return 1;
    if (fmt == FMT_LSBJ) return HALF_SLOTS - wordBits(fmt, wcode);
    return 0;
  endfunction

endpackage

// File: rtl/aud_sp_ctrl.sv
module aud_sp_ctrl
  import aud_sp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgMaster,
  input  logic [1:0]       cfgFormat,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             sckIn,
  input  logic             wsIn,
  output logic             sckOut,
  output logic             wsOut,
  output apStrobe_t        st
);

  localparam int SYNC_STAGES = 2;

  logic [DIV_W-1:0]       divCnt;
  logic                   sckGen;
  logic [SLOT_W:0]        frameSlot;
  logic [SYNC_STAGES-1:0] sckSync;
  logic [SYNC_STAGES-1:0] wsSync;
  logic                   sckPrev;
  logic                   wsAtRise;
  logic                   aligned;
  logic [SLOT_W-1:0]      pos;

  logic                   fmtI2S;
  logic                   wsGen;
  logic                   sckSel;
  logic                   wsSel;
  logic                   riseEv;
  logic                   fallEv;
  logic                   wsChange;
  logic [SLOT_W-1:0]      nextPos;

  assign fmtI2S = (cfgFormat == FMT_I2S);
  assign wsGen  = fmtI2S ? frameSlot[SLOT_W] : ~frameSlot[SLOT_W];

  // master clock generator: cleared while in slave mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt    <= '0;
      sckGen    <= 1'b0;
      frameSlot <= '1;
    end else if (!cfgMaster) begin
      divCnt    <= '0;
      sckGen    <= 1'b0;
      frameSlot <= '1;
    end else if (divCnt >= cfgDiv) begin
      divCnt <= '0;
      sckGen <= ~sckGen;
      if (sckGen) frameSlot <= frameSlot + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sckOut = sckGen;
  assign wsOut  = cfgMaster ? wsGen : 1'b0;

  // external clock synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSync <= '0;
      wsSync  <= '0;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      wsSync  <= {wsSync[SYNC_STAGES-2:0], wsIn};
    end
  end

  assign sckSel   = cfgMaster ? sckGen : sckSync[SYNC_STAGES-1];
  assign wsSel    = cfgMaster ? wsGen  : wsSync[SYNC_STAGES-1];
  assign riseEv   = sckSel & ~sckPrev;
  assign fallEv   = ~sckSel & sckPrev;
  assign wsChange = (wsSel != wsAtRise);
  assign nextPos  = wsChange ? '0 : pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPrev  <= 1'b0;
      wsAtRise <= 1'b0;
      aligned  <= 1'b0;
      pos      <= '1;
    end else begin
      sckPrev <= sckSel;
      if (riseEv) begin
        pos      <= nextPos;
        wsAtRise <= wsSel;
        if (wsChange) aligned <= 1'b1;
      end
    end
  end

  always_comb begin
    st.rise      = riseEv;
    st.fall      = fallEv;
    st.slot      = nextPos;
    st.chanRight = fmtI2S ? wsSel : ~wsSel;
    st.aligned   = aligned;
    st.loadTx    = fallEv && (nextPos == '0) && !st.chanRight;
  end

  AST_WS_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMaster && $past(cfgMaster) && (wsOut != $past(wsOut)) && (cfgFormat == $past(cfgFormat)))
      |-> (!sckOut && $past(sckOut))); // R7

  AST_SLAVE_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgMaster && !$past(cfgMaster)) |-> !sckOut); // R8

endmodule

// File: rtl/aud_sp_data.sv
module aud_sp_data
  import aud_sp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  apStrobe_t           st,
  input  logic [1:0]          cfgFormat,
  input  logic [1:0]          cfgWidth,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                sdIn,
  output logic                sdOut,
  output logic                txTake,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxLeftValid,
  output logic                rxRightValid
);

  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam int CMP_W = SLOT_W + 2;

  logic [CMP_W-1:0]    wordLen;
  logic [CMP_W-1:0]    startSlot;
  logic [CMP_W-1:0]    curSlot;
  logic [CMP_W-1:0]    relSlot;
  logic                inWord;
  logic [IDX_W-1:0]    bitIdx;
  logic [SAMPLE_W-1:0] holdL;
  logic [SAMPLE_W-1:0] holdR;
  logic [SAMPLE_W-1:0] txWord;
  logic [SAMPLE_W-1:0] asmWord;
  logic [SAMPLE_W-1:0] asmNext;
  logic                lastSlot;

  // slot-to-bit mapping shared by both directions
  always_comb begin
    wordLen   = CMP_W'(wordBits(cfgFormat, cfgWidth));
    startSlot = CMP_W'(firstSlot(cfgFormat, cfgWidth));
    curSlot   = CMP_W'(st.slot);
    relSlot   = curSlot - startSlot;
    inWord    = (curSlot >= startSlot) && (relSlot < wordLen);
    bitIdx    = IDX_W'(SAMPLE_W - 1) - IDX_W'(relSlot);
  end

  assign txWord   = st.chanRight ? holdR : (st.loadTx ? txLeft : holdL);
  assign lastSlot = (st.slot == SLOT_W'(HALF_SLOTS - 1));

  always_comb begin
    asmNext = (st.slot == '0) ? '0 : asmWord;
    if (inWord) asmNext[bitIdx] = sdIn;
  end

  // transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdOut  <= 1'b0;
      txTake <= 1'b0;
      holdL  <= '0;
      holdR  <= '0;
    end else begin
      txTake <= st.loadTx;
      if (st.fall) sdOut <= inWord ? txWord[bitIdx] : 1'b0;
      if (st.loadTx) begin
        holdL <= txLeft;
        holdR <= txRight;
      end
    end
  end

  // receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asmWord      <= '0;
      rxLeft       <= '0;
      rxRight      <= '0;
      rxLeftValid  <= 1'b0;
      rxRightValid <= 1'b0;
    end else begin
      rxLeftValid  <= 1'b0;
      rxRightValid <= 1'b0;
      if (st.rise) begin
        asmWord <= asmNext;
        if (lastSlot && st.aligned) begin
          if (st.chanRight) begin
            rxRight      <= asmNext;
            rxRightValid <= 1'b1;
          end else begin
            rxLeft      <= asmNext;
            rxLeftValid <= 1'b1;
          end
        end
      end
    end
  end

  AST_SD_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !st.fall |=> $stable(sdOut)); // R2

  AST_LEFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxLeftValid |=> !rxLeftValid); // R6

  AST_RIGHT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rxRightValid |=> !rxRightValid); // R6

  AST_NO_EARLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !st.aligned |=> (!rxLeftValid && !rxRightValid)); // R10

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    txTake |=> !txTake); // R9

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_sp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgMaster,
  input  logic [1:0]          cfgFormat,
  input  logic [1:0]          cfgWidth,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic                sckIn,
  input  logic                wsIn,
  input  logic                sdIn,
  output logic                sckOut,
  output logic                wsOut,
  output logic                sdOut,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                txTake,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxLeftValid,
  output logic                rxRightValid
);

  apStrobe_t st;

  aud_sp_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgMaster (cfgMaster),
    .cfgFormat (cfgFormat),
    .cfgDiv    (cfgDiv),
    .sckIn     (sckIn),
    .wsIn      (wsIn),
    .sckOut    (sckOut),
    .wsOut     (wsOut),
    .st        (st)
  );

  aud_sp_data data_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .cfgFormat    (cfgFormat),
    .cfgWidth     (cfgWidth),
    .txLeft       (txLeft),
    .txRight      (txRight),
    .sdIn         (sdIn),
    .sdOut        (sdOut),
    .txTake       (txTake),
    .rxLeft       (rxLeft),
    .rxRight      (rxRight),
    .rxLeftValid  (rxLeftValid),
    .rxRightValid (rxRightValid)
  );

endmodule

// File: tb/aud_serial_port_tb_top.sv
`timescale 1ns/1ps
module aud_serial_port_tb_top;

  localparam int DIV_W = 8;
  localparam int HALF  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfgMaster = 1'b0;
  logic [1:0]  cfgFormat = 2'd0;
  logic [1:0]  cfgWidth  = 2'd3;
  logic [DIV_W-1:0] cfgDiv = '0;
  logic        sckIn = 1'b0;
  logic        wsIn  = 1'b0;
  logic        sdDrv = 1'b0;
  logic        loopBack = 1'b0;
  logic        sdInW;
  logic        sckOut, wsOut, sdOut, txTake;
  logic [23:0] txLeft = '0, txRight = '0;
  logic [23:0] rxLeft, rxRight;
  logic        rxLeftValid, rxRightValid;

  int nChecks = 0;
  int nFails  = 0;
  int takeCnt = 0;
  bit monEn   = 1'b1;
  logic [24:0] expQ[$];
  logic [24:0] popped;

  always #2 clk = ~clk;
  assign sdInW = loopBack ? sdOut : sdDrv;

  aud_serial_port #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfgMaster(cfgMaster), .cfgFormat(cfgFormat),
    .cfgWidth(cfgWidth), .cfgDiv(cfgDiv), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdInW),
    .sckOut(sckOut), .wsOut(wsOut), .sdOut(sdOut), .txLeft(txLeft), .txRight(txRight),
    .txTake(txTake), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxLeftValid(rxLeftValid), .rxRightValid(rxRightValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // framing model taken from the requirements
  function automatic int wBits(input logic [1:0] f, input logic [1:0] wc);
    if (f != 2'd2) return 24;
    case (wc)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic int sSlot(input logic [1:0] f, input logic [1:0] wc);
    if (f == 2'd0) return 1;
    if (f == 2'd2) return 32 - wBits(f, wc);
    return 0;
  endfunction

  function automatic logic modelBit(input logic [1:0] f, input logic [1:0] wc,
                                    input logic [23:0] w, input int p);
    int s = sSlot(f, wc);
    int n = wBits(f, wc);
    if (p >= s && p < s + n) return w[23 - (p - s)];
    return 1'b0;
  endfunction

  function automatic logic [23:0] trunc(input logic [1:0] f, input logic [1:0] wc,
                                        input logic [23:0] w);
    logic [23:0] m = ~24'h0 << (24 - wBits(f, wc));
    return w & m;
  endfunction

  // monitor: pops expected words as the port delivers them
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (txTake) takeCnt++;
      if (rxLeftValid && rxRightValid)
        check(1'b0, "R6", "both receive strobes high", 32'd3, 32'd1);
      else if (monEn && (rxLeftValid || rxRightValid)) begin
        if (expQ.size() == 0)
          check(1'b0, "R10", "unexpected receive word", {8'h0, rxLeftValid ? rxLeft : rxRight}, 32'h0);
        else begin
          popped = expQ.pop_front();
          check(rxRightValid == popped[24] && (rxRightValid ? rxRight : rxLeft) == popped[23:0],
                "R5", rxRightValid ? "rx right word" : "rx left word",
                {7'h0, rxRightValid, rxRightValid ? rxRight : rxLeft}, {7'h0, popped});
        end
      end
    end
  end

  // slave-mode frame driver with transmit decode
  task automatic sendFrame(input logic [1:0] fmt, input logic [1:0] wc,
                           input logic [23:0] rxL, input logic [23:0] rxR,
                           input logic [23:0] txL, input logic [23:0] txR,
                           input bit expL, input bit chkTx, input bit midChange,
                           input string req);
    logic [31:0] got, want;
    int takeStart;
    cfgFormat = fmt;
    cfgWidth  = wc;
    if (expL) expQ.push_back({1'b0, trunc(fmt, wc, rxL)});
    expQ.push_back({1'b1, trunc(fmt, wc, rxR)});
    txLeft = txL;
    txRight = txR;
    takeStart = takeCnt;
    for (int h = 0; h < 2; h++) begin
      got = '0;
      want = '0;
      for (int p = 0; p < 32; p++) begin
        sckIn = 1'b0;
        wsIn  = (fmt == 2'd0) ? h[0] : ~h[0];
        sdDrv = modelBit(fmt, wc, (h != 0) ? rxR : rxL, p);
        if (midChange && h == 0 && p == 4) begin
          txLeft  = ~txL;
          txRight = ~txR;
        end
        repeat (HALF) @(negedge clk);
        got[31 - p]  = sdOut;
        want[31 - p] = modelBit(fmt, wc, (h != 0) ? txR : txL, p);
        sckIn = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      if (chkTx) check(got == want, req, (h != 0) ? "tx right slots" : "tx left slots", got, want);
    end
    if (chkTx) check(takeCnt - takeStart == 1, "R9", "txTake pulses per frame", takeCnt - takeStart, 1);
  endtask

  task automatic armLoop(input logic [1:0] fmt, input logic [1:0] wc, input string req);
    int waitCnt;
    @(posedge wsOut);
    #1;
    check(sckOut == 1'b0, "R7", "wsOut edge with sck low", {31'h0, sckOut}, 32'h0);
    expQ.delete();
    for (int k = 0; k < 2; k++) begin
      expQ.push_back({1'b0, trunc(fmt, wc, txLeft)});
      expQ.push_back({1'b1, trunc(fmt, wc, txRight)});
    end
    monEn = 1'b1;
    waitCnt = 0;
    while (expQ.size() != 0 && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(expQ.size() == 0, req, "loopback words delivered", expQ.size(), 0);
    monEn = 1'b0;
  endtask

  task automatic measure(input int expPer);
    realtime t0;
    realtime tw;
    int per;
    @(posedge sckOut);
    t0 = $realtime;
    @(posedge sckOut);
    per = int'(($realtime - t0) / 4.0);
    check(per == expPer, "R7", "sckOut period in clocks", per, expPer);
    @(posedge wsOut);
    tw = $realtime;
    @(negedge wsOut);
    check(int'(($realtime - tw) / ($realtime - tw > 0 ? real'(per) * 4.0 : 1.0)) == 32,
          "R7", "bit clocks per wsOut level", int'(($realtime - tw) / (real'(per) * 4.0)), 32);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check({sdOut, sckOut, wsOut, txTake, rxLeftValid, rxRightValid} == 6'b0,
          "R1", "outputs in reset", {26'h0, sdOut, sckOut, wsOut, txTake, rxLeftValid, rxRightValid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({sdOut, sckOut, wsOut, txTake, rxLeftValid, rxRightValid} == 6'b0,
          "R1", "outputs after reset", {26'h0, sdOut, sckOut, wsOut, txTake, rxLeftValid, rxRightValid}, 0);

    // R10: first left half has no word-select transition, so only the right word is due
    sendFrame(2'd0, 2'd3, 24'h111111, 24'h222222, 24'h0, 24'h0, 1'b0, 1'b0, 1'b0, "R10");
    check(expQ.size() == 0, "R10", "only right word after first transition", expQ.size(), 0);

    // I2S
    sendFrame(2'd0, 2'd3, 24'hA5C3F1, 24'h5A3C0E, 24'h800001, 24'h7FFFFE, 1'b1, 1'b1, 1'b0, "R2");
    sendFrame(2'd0, 2'd0, 24'hFFFFFF, 24'h000001, 24'h123456, 24'hFEDCBA, 1'b1, 1'b1, 1'b0, "R2");
    // left-justified, codes 1 and 3
    sendFrame(2'd1, 2'd0, 24'h96E1D2, 24'h0F0F0F, 24'hC00003, 24'h3FFFFC, 1'b1, 1'b1, 1'b0, "R3");
    sendFrame(2'd3, 2'd0, 24'h800000, 24'hFFFFFF, 24'hABCDEF, 24'h000001, 1'b1, 1'b1, 1'b0, "R3");
    // right-justified at each length
    sendFrame(2'd2, 2'd0, 24'hFEDCBA, 24'h13579B, 24'hFFFF01, 24'h8001FF, 1'b1, 1'b1, 1'b0, "R4");
    sendFrame(2'd2, 2'd1, 24'hFFFFFF, 24'hA5A5A5, 24'hC0FFEE, 24'h7F00C3, 1'b1, 1'b1, 1'b0, "R4");
    sendFrame(2'd2, 2'd2, 24'h5555AA, 24'hFFF00F, 24'hDEADBE, 24'h00F0F0, 1'b1, 1'b1, 1'b0, "R4");
    sendFrame(2'd2, 2'd3, 24'h000001, 24'h800000, 24'h654321, 24'hF00001, 1'b1, 1'b1, 1'b0, "R4");
    // R9: samples changed mid-frame must not show up in the frame
    sendFrame(2'd1, 2'd0, 24'h3C3C3C, 24'hC3C3C3, 24'h1E2D3C, 24'hE1D2C3, 1'b1, 1'b1, 1'b1, "R9");
    check(expQ.size() == 0, "R5", "all slave words delivered", expQ.size(), 0);
    // R8: generated clock outputs stay low in slave mode
    check({sckOut, wsOut} == 2'b00, "R8", "sckOut/wsOut in slave mode", {30'h0, sckOut, wsOut}, 0);

    // master mode with data looped back
    monEn = 1'b0;
    txLeft  = 24'h3C5A96;
    txRight = 24'hC3A569;
    cfgFormat = 2'd1;
    cfgDiv = 8'd3;
    loopBack = 1'b1;
    cfgMaster = 1'b1;
    repeat (2) @(posedge wsOut);
    measure(8);
    armLoop(2'd1, 2'd3, "R7");

    cfgFormat = 2'd2;
    cfgWidth  = 2'd0;
    cfgDiv    = 8'd1;
    repeat (2) @(posedge wsOut);
    measure(4);
    armLoop(2'd2, 2'd0, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule